// File: doc/BRIEF.md
# Two-Channel Priority Interrupt Arbiter

This block chooses one winning interrupt line out of a set of sources grouped into banks of equal size. Two arbitration channels run side by side, a normal channel and a fast channel. A per-line steering bit assigns each line to one of them. A line competes in a channel only when it is pending, its mask bit is clear, and its steering bit selects that channel. Every line carries a programmable priority. The smallest priority value is the most urgent.

Each channel has an arm flag. When an armed channel sees at least one eligible line and the global enable is high, it fires on the clock edge. Firing stores the winner's vector, raises the channel's request output and clears the arm flag. The request then stays high and the vector stays frozen until software pulses that channel's re-arm strobe. A re-arm drops the request and arms the channel again. If a candidate is already present during the re-arm cycle, the channel re-fires on that same edge with a freshly chosen vector.

The vector is the flat line number: bank number times the bank size, plus the line offset within the bank. Bus decoding and input sensing are outside this block. Pending, mask, steering and priority arrive here as plain vectors.

Top module: `irq_prio_arbiter`

## Requirements
- R1: A line is eligible for the normal channel only when its pending bit is 1, its mask bit is 0 and its steering bit is 0. Masked lines never win.
- R2: A line is eligible for the fast channel only when its pending bit is 1, its mask bit is 0 and its steering bit is 1.
- R3: Among eligible lines, the one with the numerically smallest priority value wins.
- R4: When several eligible lines share the smallest priority value, the one with the highest flat line number wins. This holds inside one bank and across banks.
- R5: The vector output equals bank_number * 32 + line_offset, which is the flat line number (line_prio holds line k in bits [k*PRIO_W +: PRIO_W]).
- R6: An armed channel with an eligible line and glob_en high raises its request on the next clock edge. On that edge it latches the winning vector and disarms.
- R7: While a channel's request is high and no re-arm is given, the request stays high and the vector does not change, even if a more urgent line appears.
- R8: A re-arm pulse with no eligible line drops that channel's request on the next edge and arms it. A line that becomes eligible later then fires the channel.
- R9: A re-arm pulse while an eligible line exists fires the channel on that same edge, with the vector of the current winner.
- R10: When no line is eligible, the channel's vector keeps its previous value and its request does not rise.
- R11: After reset both requests are low, both vectors are 0 and both channels are armed.
- R12: While glob_en is low, no channel fires and its arm flag is kept. Raising glob_en lets a pending candidate fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_pend | input | NUM_LINES | Per-line pending bits |
| line_mask | input | NUM_LINES | Per-line mask bits (1 = blocked) |
| line_steer | input | NUM_LINES | Per-line channel select (1 = fast) |
| line_prio | input | NUM_LINES*PRIO_W | Per-line priority, line k at [k*PRIO_W +: PRIO_W] |
| glob_en | input | 1 | Global enable for firing |
| rearm_norm | input | 1 | Re-arm strobe, normal channel |
| rearm_fast | input | 1 | Re-arm strobe, fast channel |
| req_norm | output | 1 | Normal channel request |
| req_fast | output | 1 | Fast channel request |
| vec_norm | output | VEC_W | Latched normal-channel vector |
| vec_fast | output | VEC_W | Latched fast-channel vector |

## Verification
The assertions check the channel handshake on every cycle. They cover the reset values, firing with the winner's vector one edge after an armed candidate, a held request with a frozen vector while disarmed, a dropped request after a re-arm with no candidate, and a vector that holds while nothing is eligible. The assertions cannot show which line should have won. Only the bench's scenarios, compared against an independent reference scan, show correct steering, masking, lowest-value-first ordering and tie breaking toward the highest line within and across banks.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int NUM_CH = 2;

  typedef enum logic {
    CH_NORM = 1'b0,
    CH_FAST = 1'b1
  } chan_e;
endpackage

// File: rtl/irq_bank_pick.sv
// Picks the best eligible line inside one bank: ascending scan, ties go to later lines
module irq_bank_pick #(
  parameter int LINES  = 32,
  parameter int PRIO_W = 6,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic [LINES-1:0]        elig,
  input  logic [LINES*PRIO_W-1:0] prio,
  output logic                    hit,
  output logic [IDX_W-1:0]        best_idx,
  output logic [PRIO_W-1:0]       best_prio
);
  always_comb begin
    hit       = 1'b0;
    best_idx  = '0;
    best_prio = '1;
    for (int i = 0; i < LINES; i++) begin
      if (elig[i] && (!hit || prio[i*PRIO_W +: PRIO_W] <= best_prio)) begin
        hit       = 1'b1;
        best_idx  = IDX_W'(i);
        best_prio = prio[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/irq_bank_merge.sv
// Merges per-bank winners; a later bank wins a priority tie
module irq_bank_merge #(
  parameter int NBANKS = 3,
  parameter int IDX_W  = 5,
  parameter int PRIO_W = 6,
  parameter int VEC_W  = 7
) (
  input  logic [NBANKS-1:0]        bank_hit,
  input  logic [NBANKS*IDX_W-1:0]  bank_idx,
  input  logic [NBANKS*PRIO_W-1:0] bank_prio,
  output logic                     any,
  output logic [VEC_W-1:0]         vec
);
  logic [PRIO_W-1:0] cur;

  always_comb begin
    any = 1'b0;
    vec = '0;
    cur = '1;
    for (int b = 0; b < NBANKS; b++) begin
      if (bank_hit[b] && (!any || bank_prio[b*PRIO_W +: PRIO_W] <= cur)) begin
        any = 1'b1;
        cur = bank_prio[b*PRIO_W +: PRIO_W];
        vec = VEC_W'(b * (1 << IDX_W)) + VEC_W'(bank_idx[b*IDX_W +: IDX_W]);
      end
    end
  end
endmodule

// File: rtl/irq_chan_ctrl.sv
// One-shot arm / fire / re-arm control for one channel
module irq_chan_ctrl #(
  parameter int VEC_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cand_any,
  input  logic [VEC_W-1:0] cand_vec,
  input  logic             glob_en,
  input  logic             rearm,
  output logic             req,
  output logic [VEC_W-1:0] vec
);
  logic arm_q;
  logic fire;

  // a re-arm counts as armed in the same cycle, so it can re-fire at once
  assign fire = (arm_q | rearm) & cand_any & glob_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= 1'b1;
      req   <= 1'b0;
      vec   <= '0;
    end else if (fire) begin
      arm_q <= 1'b0;
      req   <= 1'b1;
      vec   <= cand_vec;
    end else if (rearm) begin
      arm_q <= 1'b1;
      req   <= 1'b0;
    end
  end

  // R11
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!req && vec == '0 && arm_q));

  // R6
  fire_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((arm_q || rearm) && cand_any && glob_en) |=> (req && !arm_q && vec == $past(cand_vec)));

  // R7
  hold_while_disarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !rearm) |=> (req && $stable(vec)));

  // R8
  rearm_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rearm && !cand_any) |=> (!req && arm_q));

  // R10
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cand_any |=> $stable(vec));

  // R12
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!glob_en && !req) |=> !req);
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_BANKS      = 3,
  parameter int LINES_PER_BANK = 32,
  parameter int PRIO_W         = 6,
  localparam int NUM_LINES     = NUM_BANKS * LINES_PER_BANK,
  localparam int VEC_W         = $clog2(NUM_LINES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_LINES-1:0]        line_pend,
  input  logic [NUM_LINES-1:0]        line_mask,
  input  logic [NUM_LINES-1:0]        line_steer,
  input  logic [NUM_LINES*PRIO_W-1:0] line_prio,
  input  logic                        glob_en,
  input  logic                        rearm_norm,
  input  logic                        rearm_fast,
  output logic                        req_norm,
  output logic                        req_fast,
  output logic [VEC_W-1:0]            vec_norm,
  output logic [VEC_W-1:0]            vec_fast
);
  localparam int IDX_W = $clog2(LINES_PER_BANK);

  logic [NUM_CH-1:0] rearm_ch;
  logic [NUM_CH-1:0] req_ch;
  logic [VEC_W-1:0]  vec_ch [NUM_CH];

  assign rearm_ch[CH_NORM] = rearm_norm;
  assign rearm_ch[CH_FAST] = rearm_fast;
  assign req_norm = req_ch[CH_NORM];
  assign req_fast = req_ch[CH_FAST];
  assign vec_norm = vec_ch[CH_NORM];
  assign vec_fast = vec_ch[CH_FAST];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [NUM_LINES-1:0]        elig;
    logic [NUM_BANKS-1:0]        b_hit;
    logic [NUM_BANKS*IDX_W-1:0]  b_idx;
    logic [NUM_BANKS*PRIO_W-1:0] b_prio;
    logic                        c_any;
    logic [VEC_W-1:0]            c_vec;

    // steering bit selects the channel: 1 = fast, 0 = normal
    if (c == int'(CH_FAST)) begin : g_fast
      assign elig = line_pend & ~line_mask & line_steer;
    end else begin : g_norm
      assign elig = line_pend & ~line_mask & ~line_steer;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      irq_bank_pick #(
        .LINES (LINES_PER_BANK),
        .PRIO_W(PRIO_W)
      ) u_pick (
        .elig     (elig[b*LINES_PER_BANK +: LINES_PER_BANK]),
        .prio     (line_prio[b*LINES_PER_BANK*PRIO_W +: LINES_PER_BANK*PRIO_W]),
        .hit      (b_hit[b]),
        .best_idx (b_idx[b*IDX_W +: IDX_W]),
        .best_prio(b_prio[b*PRIO_W +: PRIO_W])
      );
    end

    irq_bank_merge #(
      .NBANKS(NUM_BANKS),
      .IDX_W (IDX_W),
      .PRIO_W(PRIO_W),
      .VEC_W (VEC_W)
    ) u_merge (
      .bank_hit (b_hit),
      .bank_idx (b_idx),
      .bank_prio(b_prio),
      .any      (c_any),
      .vec      (c_vec)
    );

    irq_chan_ctrl #(
      .VEC_W(VEC_W)
    ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .cand_any(c_any),
      .cand_vec(c_vec),
      .glob_en (glob_en),
      .rearm   (rearm_ch[c]),
      .req     (req_ch[c]),
      .vec     (vec_ch[c])
    );
  end
endmodule

// File: tb/tb_irq_prio_arbiter.sv
module tb_irq_prio_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 3;
  localparam int LPB = 32;
  localparam int PW = 6;
  localparam int NL = NB * LPB;
  localparam int VW = $clog2(NL);

  typedef struct packed {
    logic [6:0]  la; logic [5:0] pa;
    logic [6:0]  lb; logic [5:0] pb;
    logic [6:0]  lc; logic [5:0] pc;
    logic [2:0]  steer;  // bit0 -> a, bit1 -> b, bit2 -> c
    logic [2:0]  mask;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TABLE [NV] = '{
    '{7'd5,  6'd10, 7'd40, 6'd3,  7'd90, 6'd1,  3'b000, 3'b100}, // R1 R3 mask hides most urgent
    '{7'd5,  6'd7,  7'd40, 6'd7,  7'd90, 6'd7,  3'b000, 3'b000}, // R4 across banks
    '{7'd3,  6'd2,  7'd4,  6'd2,  7'd70, 6'd9,  3'b000, 3'b000}, // R4 within bank
    '{7'd3,  6'd1,  7'd4,  6'd2,  7'd70, 6'd0,  3'b100, 3'b000}, // R2 steering split
    '{7'd8,  6'd1,  7'd9,  6'd2,  7'd10, 6'd0,  3'b010, 3'b111}, // R10 all masked
    '{7'd0,  6'd0,  7'd95, 6'd63, 7'd31, 6'd0,  3'b000, 3'b000}, // R4 R5 prio 0 tie
    '{7'd95, 6'd0,  7'd94, 6'd1,  7'd93, 6'd0,  3'b111, 3'b000}, // R2 R10 fast only
    '{7'd64, 6'd5,  7'd63, 6'd5,  7'd32, 6'd4,  3'b011, 3'b000}  // R4 R9 fast tie, norm single
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NL-1:0] pend = '0, mask = '0, steer = '0;
  logic [PW-1:0] prio [NL];
  logic [NL*PW-1:0] prio_flat;
  logic glob_en = 1'b1, rearm_norm = 1'b0, rearm_fast = 1'b0;
  logic req_norm, req_fast;
  logic [VW-1:0] vec_norm, vec_fast;

  int checks = 0, errors = 0;
  bit done = 0;
  int exp_vn = 0, exp_vf = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb
    for (int k = 0; k < NL; k++) prio_flat[k*PW +: PW] = prio[k];

  irq_prio_arbiter #(.NUM_BANKS(NB), .LINES_PER_BANK(LPB), .PRIO_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .line_pend(pend), .line_mask(mask),
    .line_steer(steer), .line_prio(prio_flat), .glob_en(glob_en),
    .rearm_norm(rearm_norm), .rearm_fast(rearm_fast),
    .req_norm(req_norm), .req_fast(req_fast),
    .vec_norm(vec_norm), .vec_fast(vec_fast));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // reference: descending scan, strict improvement -> highest line wins ties
  function automatic int model(input bit fast, output bit hit);
    int best = 1 << PW;
    int win = 0;
    hit = 0;
    for (int k = NL - 1; k >= 0; k--) begin
      if (pend[k] && !mask[k] && (steer[k] == fast) && int'(prio[k]) < best) begin
        best = int'(prio[k]);
        win = k;
        hit = 1;
      end
    end
    return win;
  endfunction

  task automatic clear_lines();
    pend = '0; mask = '0; steer = '0;
    for (int k = 0; k < NL; k++) prio[k] = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit hn, hf;
    int wn, wf;
    clear_lines();
    repeat (3) @(negedge clk);
    // R11 reset values
    check("R11 req_norm", int'(req_norm), 0);
    check("R11 req_fast", int'(req_fast), 0);
    check("R11 vec_norm", int'(vec_norm), 0);
    check("R11 vec_fast", int'(vec_fast), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 armed from reset: a candidate fires without any re-arm
    pend[10] = 1'b1; prio[10] = 6'd3;
    @(negedge clk);
    check("R11 R6 armed fire req", int'(req_norm), 1);
    check("R11 R6 armed fire vec", int'(vec_norm), 10);
    exp_vn = 10;

    // table walk: each entry re-arms both channels with its stimulus applied (R9)
    for (int e = 0; e < NV; e++) begin
      clear_lines();
      pend[TABLE[e].la] = 1'b1; prio[TABLE[e].la] = TABLE[e].pa;
      pend[TABLE[e].lb] = 1'b1; prio[TABLE[e].lb] = TABLE[e].pb;
      pend[TABLE[e].lc] = 1'b1; prio[TABLE[e].lc] = TABLE[e].pc;
      steer[TABLE[e].la] = TABLE[e].steer[0];
      steer[TABLE[e].lb] = TABLE[e].steer[1];
      steer[TABLE[e].lc] = TABLE[e].steer[2];
      mask[TABLE[e].la] = TABLE[e].mask[0];
      mask[TABLE[e].lb] = TABLE[e].mask[1];
      mask[TABLE[e].lc] = TABLE[e].mask[2];
      rearm_norm = 1'b1; rearm_fast = 1'b1;
      @(negedge clk);
      rearm_norm = 1'b0; rearm_fast = 1'b0;
      wn = model(1'b0, hn);
      wf = model(1'b1, hf);
      if (hn) exp_vn = wn;
      if (hf) exp_vf = wf;
      check($sformatf("R1 R3 R4 R9 entry %0d req_norm", e), int'(req_norm), int'(hn));
      check($sformatf("R1 R3 R4 R5 entry %0d vec_norm", e), int'(vec_norm), exp_vn);
      check($sformatf("R2 R9 entry %0d req_fast", e), int'(req_fast), int'(hf));
      check($sformatf("R2 R5 R10 entry %0d vec_fast", e), int'(vec_fast), exp_vf);
    end

    // R12: enable low blocks firing, arm is kept
    clear_lines();
    glob_en = 1'b0;
    rearm_norm = 1'b1; rearm_fast = 1'b1;
    @(negedge clk);
    rearm_norm = 1'b0; rearm_fast = 1'b0;
    pend[7] = 1'b1; prio[7] = 6'd12;
    repeat (2) @(negedge clk);
    check("R12 no fire while disabled", int'(req_norm), 0);
    glob_en = 1'b1;
    @(negedge clk);
    check("R12 fire after enable req", int'(req_norm), 1);
    check("R12 fire after enable vec", int'(vec_norm), 7);

    // R7: more urgent line while disarmed changes nothing
    pend[50] = 1'b1; prio[50] = 6'd0;
    repeat (2) @(negedge clk);
    check("R7 req held", int'(req_norm), 1);
    check("R7 vec frozen", int'(vec_norm), 7);

    // R8 R10: re-arm with nothing eligible
    clear_lines();
    rearm_norm = 1'b1;
    @(negedge clk);
    rearm_norm = 1'b0;
    check("R8 req dropped", int'(req_norm), 0);
    check("R10 vec kept", int'(vec_norm), 7);
    @(negedge clk);
    check("R8 still low without candidate", int'(req_norm), 0);
    pend[20] = 1'b1; prio[20] = 6'd5;
    @(negedge clk);
    check("R8 later candidate fires req", int'(req_norm), 1);
    check("R8 later candidate vec", int'(vec_norm), 20);
    check("R1 normal line leaves fast low", int'(req_fast), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule